// File: doc/BRIEF.md
# Data Tenure Termination Controller

This block is the master side of the data phase on a processor bus where address and data phases are split. Once the data bus has been granted, it accepts a request for either one beat or a fixed-length burst. It drives a data-bus-busy output for the length of the tenure and counts the beats the slave acknowledges. It also resolves three ways a tenure can end: a transfer acknowledge on the final beat, a transfer error, or an address retry.

Every tenure ends with exactly one outcome. That outcome appears as a one-cycle done pulse carrying a status code and the number of beats that were accepted. An errored tenure also raises one of two requests. A machine-check request is raised when the enable input is set, and a checkstop request is raised when it is clear. Acknowledges are not honoured until the address-retry window for the transaction has opened, so no data moves while the address could still be retried. After every tenure, busy goes low before another tenure may begin.

Top module: `data_tenure_ctrl`

## Requirements
- R1: In idle, a tenure starts only when `req_i` and `gnt_i` are both high at a clock edge, and `busy_o` is high from the following cycle. A request without a grant is ignored.
- R2: While busy, an acknowledge that arrives with the retry window open accepts a beat, signalled by `beat_o` in the same cycle. The slave may insert any number of wait cycles between beats.
- R3: An acknowledge that arrives before `win_i` has been seen during the tenure is ignored. `beat_o` stays low and the beat is not counted.
- R4: A single-beat tenure (`burst_i`=0) completes on its first accepted beat. A burst (`burst_i`=1) completes on its fourth. Completion gives `done_o` with `status_o`=2'b00 and `beats_o` equal to the beat total.
- R5: An address retry while busy ends the tenure at that edge, whether or not the window is open. The outcome is `status_o`=2'b10, and `beats_o` holds the beats accepted before the retry.
- R6: When retry and error arrive in the same cycle, the retry wins. The status is 2'b10 and no error request is raised.
- R7: A transfer error while busy ends the tenure at that edge, even partway through a burst. The status is 2'b01, and `beats_o` keeps the beats acknowledged before the error.
- R8: An error outcome raises `mcheck_o` when `mce_i` is high in the terminating cycle, and `cstop_o` otherwise. Each is a one-cycle pulse aligned with `done_o`, and neither fires for any other outcome.
- R9: `busy_o` is low in the cycle that follows any termination. A request in that cycle is ignored, and a request in the next cycle is accepted.
- R10: `done_o` is high for exactly one cycle per tenure.
- R11: `beat_o` is never high in a cycle in which error or retry is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Tenure request |
| gnt_i | input | 1 | Data bus granted |
| burst_i | input | 1 | 1 = four-beat burst, 0 = single beat |
| win_i | input | 1 | First cycle of the address-retry window has been reached |
| ack_i | input | 1 | Transfer acknowledge from the slave |
| err_i | input | 1 | Transfer error from the slave |
| retry_i | input | 1 | Address retry for this transaction |
| mce_i | input | 1 | Machine-check enable |
| busy_o | output | 1 | Data bus busy |
| beat_o | output | 1 | Beat accepted this cycle |
| done_o | output | 1 | Tenure outcome valid (one cycle) |
| status_o | output | 2 | 00 OK, 01 error, 10 retry |
| beats_o | output | 3 | Beats accepted in the tenure (0 to 4) |
| mcheck_o | output | 1 | Machine-check request pulse |
| cstop_o | output | 1 | Checkstop request pulse |

## Verification
The assertions assume that the slave drives acknowledge, error and retry only to the tenure in progress. They also assume that the retry window signal refers to the transaction currently on the bus, so any of these inputs arriving outside busy carries no meaning. The directed stimulus raises these inputs only while `busy_o` is high, and it clears them in the cycle in which the outcome is reported. The stimulus also presents acknowledges before the window opens, mixes wait cycles between beats, and drives error together with retry, so that every termination priority is reached.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [1:0] {
    DT_OK    = 2'b00,
    DT_ERR   = 2'b01,
    DT_RETRY = 2'b10
  } dt_status_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_GAP
  } dt_state_e;
endpackage

// File: rtl/dt_beat_counter.sv
module dt_beat_counter #(
  parameter int BURST_LEN = 4,
  parameter int CW        = $clog2(BURST_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          burst_i,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] BurstLast = CW'(BURST_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_nxt_o = cnt_q + CW'(inc_i);
  // true while the beat in flight would be the final one
  assign last_o    = burst_i ? (cnt_q == BurstLast) : (cnt_q == '0);
endmodule

// File: rtl/dt_retry_window.sv
module dt_retry_window (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic win_i,
  output logic open_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= 1'b0;
    else if (!active_i) seen_q <= 1'b0;
    else if (win_i)     seen_q <= 1'b1;
  end

  assign open_o = active_i & (seen_q | win_i);
endmodule

// File: rtl/dt_term_arb.sv
module dt_term_arb
  import dt_pkg::*;
(
  input  logic       active_i,
  input  logic       ack_i,
  input  logic       err_i,
  input  logic       retry_i,
  input  logic       win_open_i,
  input  logic       last_i,
  output logic       accept_o,
  output logic       term_o,
  output dt_status_e code_o
);
  // fixed priority: retry > error > acknowledge
  always_comb begin
    accept_o = 1'b0;
    term_o   = 1'b0;
    code_o   = DT_OK;
    if (active_i) begin
      if (retry_i) begin
        term_o = 1'b1;
        code_o = DT_RETRY;
      end else if (err_i) begin
        term_o = 1'b1;
        code_o = DT_ERR;
      end else if (ack_i && win_open_i) begin
        accept_o = 1'b1;
        term_o   = last_i;
      end
    end
  end
endmodule

// File: rtl/data_tenure_ctrl.sv
module data_tenure_ctrl
  import dt_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic                             gnt_i,
  input  logic                             burst_i,
  input  logic                             win_i,
  input  logic                             ack_i,
  input  logic                             err_i,
  input  logic                             retry_i,
  input  logic                             mce_i,
  output logic                             busy_o,
  output logic                             beat_o,
  output logic                             done_o,
  output logic [1:0]                       status_o,
  output logic [$clog2(BURST_LEN+1)-1:0]   beats_o,
  output logic                             mcheck_o,
  output logic                             cstop_o
);
  localparam int CW = $clog2(BURST_LEN + 1);

  dt_state_e     state_q;
  logic          burst_q;
  logic          active, start;
  logic          win_open, accept, term, last;
  dt_status_e    code;
  logic [CW-1:0] cnt_nxt;

  logic          done_q, mck_q, cks_q;
  dt_status_e    status_q;
  logic [CW-1:0] beats_q;

  assign active = (state_q == ST_BUSY);
  assign start  = (state_q == ST_IDLE) && req_i && gnt_i;

  dt_retry_window u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .win_i   (win_i),
    .open_o  (win_open)
  );

  dt_beat_counter #(.BURST_LEN(BURST_LEN), .CW(CW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start),
    .inc_i    (accept),
    .burst_i  (burst_q),
    .cnt_nxt_o(cnt_nxt),
    .last_o   (last)
  );

  dt_term_arb u_arb (
    .active_i  (active),
    .ack_i     (ack_i),
    .err_i     (err_i),
    .retry_i   (retry_i),
    .win_open_i(win_open),
    .last_i    (last),
    .accept_o  (accept),
    .term_o    (term),
    .code_o    (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      burst_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_BUSY;
          burst_q <= burst_i;
        end
        ST_BUSY: if (term) state_q <= ST_GAP;
        ST_GAP:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      status_q <= DT_OK;
      beats_q  <= '0;
      mck_q    <= 1'b0;
      cks_q    <= 1'b0;
    end else begin
      done_q <= term;
      mck_q  <= term && (code == DT_ERR) && mce_i;
      cks_q  <= term && (code == DT_ERR) && !mce_i;
      if (term) begin
        status_q <= code;
        beats_q  <= cnt_nxt;
      end
    end
  end

  assign busy_o   = active;
  assign beat_o   = accept;
  assign done_o   = done_q;
  assign status_o = status_q;
  assign beats_o  = beats_q;
  assign mcheck_o = mck_q;
  assign cstop_o  = cks_q;
endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
  parameter int BURST_LEN = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           win_i,
  input logic                           err_i,
  input logic                           retry_i,
  input logic                           busy_o,
  input logic                           beat_o,
  input logic                           done_o,
  input logic [1:0]                     status_o,
  input logic [$clog2(BURST_LEN+1)-1:0] beats_o,
  input logic                           mcheck_o,
  input logic                           cstop_o
);
  logic win_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_seen <= 1'b0;
    else if (!busy_o) win_seen <= 1'b0;
    else if (win_i)   win_seen <= 1'b1;
  end

  AST_NO_EARLY_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |-> (win_i || win_seen)); // R3
  AST_RETRY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && retry_i) |=> (done_o && status_o == 2'b10)); // R5
  AST_RETRY_OVER_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && retry_i && err_i) |=> (!mcheck_o && !cstop_o)); // R6
  AST_ERR_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && err_i && !retry_i) |=> (done_o && status_o == 2'b01)); // R7
  AST_ERR_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcheck_o || cstop_o) |-> (done_o && status_o == 2'b01 && !(mcheck_o && cstop_o))); // R8
  AST_ERR_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'b01) |-> $onehot0({mcheck_o, cstop_o}) && (mcheck_o || cstop_o)); // R8
  AST_BUSY_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_GAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |=> !busy_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_BEATS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (beats_o <= BURST_LEN)); // R4
  AST_CLEAN_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |-> (!err_i && !retry_i)); // R11
endmodule

bind data_tenure_ctrl dt_checker #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .win_i   (win_i),
  .err_i   (err_i),
  .retry_i (retry_i),
  .busy_o  (busy_o),
  .beat_o  (beat_o),
  .done_o  (done_o),
  .status_o(status_o),
  .beats_o (beats_o),
  .mcheck_o(mcheck_o),
  .cstop_o (cstop_o)
);

// File: tb/sim_data_tenure_ctrl.sv
`timescale 1ns/1ps
module sim_data_tenure_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 0, gnt_i = 0, burst_i = 0, win_i = 0;
  logic ack_i = 0, err_i = 0, retry_i = 0, mce_i = 0;
  logic busy_o, beat_o, done_o, mcheck_o, cstop_o;
  logic [1:0] status_o;
  logic [2:0] beats_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  data_tenure_ctrl #(.BURST_LEN(4)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .gnt_i(gnt_i),
    .burst_i(burst_i), .win_i(win_i), .ack_i(ack_i), .err_i(err_i),
    .retry_i(retry_i), .mce_i(mce_i), .busy_o(busy_o), .beat_o(beat_o),
    .done_o(done_o), .status_o(status_o), .beats_o(beats_o),
    .mcheck_o(mcheck_o), .cstop_o(cstop_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    req_i = 0; gnt_i = 0; win_i = 0; ack_i = 0; err_i = 0; retry_i = 0;
  endtask

  // request at this negedge, busy expected at the next one
  task automatic start(input logic b);
    req_i = 1; gnt_i = 1; burst_i = b;
    @(negedge clk_i);
    req_i = 0; gnt_i = 0;
    chk("R1", "busy after start", int'(busy_o), 1);
  endtask

  // drive one busy cycle, return beat_o seen in that cycle
  task automatic step(input logic a, input logic e, input logic r, input logic w,
                      output logic b);
    ack_i = a; err_i = e; retry_i = r; win_i = w;
    #1 b = beat_o;
    @(negedge clk_i);
    clear_in();
  endtask

  task automatic expect_done(input string req, input int st, input int nb,
                             input int mck, input int cks);
    chk(req, "done", int'(done_o), 1);
    chk(req, "status", int'(status_o), st);
    chk(req, "beats", int'(beats_o), nb);
    chk("R8", "mcheck", int'(mcheck_o), mck);
    chk("R8", "cstop", int'(cstop_o), cks);
    chk("R9", "busy low after end", int'(busy_o), 0);
    @(negedge clk_i);
    chk("R10", "done one cycle", int'(done_o), 0);
  endtask

  task automatic t_reset();
    chk("R1", "reset busy", int'(busy_o), 0);
    chk("R10", "reset done", int'(done_o), 0);
    chk("R8", "reset mcheck", int'(mcheck_o | cstop_o), 0);
  endtask

  task automatic t_no_grant();
    req_i = 1; gnt_i = 0;
    repeat (2) @(negedge clk_i);
    chk("R1", "request without grant", int'(busy_o), 0);
    clear_in();
  endtask

  task automatic t_single();
    logic b;
    start(1'b0);
    step(1, 0, 0, 1, b);
    chk("R2", "beat with ack", int'(b), 1);
    expect_done("R4", 0, 1, 0, 0);
  endtask

  task automatic t_burst_holdoff();
    logic b;
    start(1'b1);
    step(1, 0, 0, 0, b);
    chk("R3", "ack before window", int'(b), 0);
    step(0, 0, 0, 1, b);
    chk("R3", "window only", int'(b), 0);
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, 0, b);  // wait state
      chk("R2", "no beat in wait", int'(b), 0);
      step(1, 0, 0, 0, b);
      chk("R2", "burst beat", int'(b), 1);
      if (i < 3) chk("R4", "no early done", int'(done_o), 0);
    end
    expect_done("R4", 0, 4, 0, 0);
  endtask

  task automatic t_retry_mid();
    logic b;
    mce_i = 1;
    start(1'b1);
    step(1, 0, 0, 1, b);
    step(1, 0, 0, 0, b);
    step(1, 1, 1, 0, b);
    chk("R11", "no beat under retry", int'(b), 0);
    expect_done("R6", 2, 2, 0, 0);
    mce_i = 0;
  endtask

  task automatic t_err_mcheck();
    logic b;
    mce_i = 1;
    start(1'b1);
    step(1, 0, 0, 1, b);
    step(1, 1, 0, 0, b);
    chk("R11", "no beat under error", int'(b), 0);
    expect_done("R7", 1, 1, 1, 0);
    mce_i = 0;
  endtask

  task automatic t_err_cstop();
    logic b;
    mce_i = 0;
    start(1'b0);
    step(0, 1, 0, 0, b);
    expect_done("R7", 1, 0, 0, 1);
  endtask

  task automatic t_retry_early();
    logic b;
    start(1'b1);
    step(1, 0, 1, 0, b);
    expect_done("R5", 2, 0, 0, 0);
  endtask

  task automatic t_gap();
    logic b;
    start(1'b0);
    step(1, 0, 0, 1, b);
    // now in the cycle after termination
    chk("R9", "busy low in gap", int'(busy_o), 0);
    req_i = 1; gnt_i = 1; burst_i = 0;
    @(negedge clk_i);
    chk("R9", "request in gap ignored", int'(busy_o), 0);
    @(negedge clk_i);
    req_i = 0; gnt_i = 0;
    chk("R9", "request after gap accepted", int'(busy_o), 1);
    step(1, 0, 0, 1, b);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_no_grant();
    t_single();
    t_burst_holdoff();
    t_retry_mid();
    t_err_mcheck();
    t_err_cstop();
    t_retry_early();
    t_gap();
    repeat (2) @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20000 * 4);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule